// File: doc/BRIEF.md
# Selectable Serial Line Code Encoder

This block turns a stream of single data bits into a line signal. Four codes are available: plain two-level NRZ, transition-coded NRZI, three-level return-to-zero, and Manchester. The block runs from a clock at twice the bit rate, so each bit takes exactly two clock cycles, called the first half and the second half. One shared timing engine serves all four codes. The output is a registered 2-bit signed level: `01` means +1, `00` means 0 and `11` means -1. The code `10` is never produced.

Bits enter through a valid/ready handshake. `in_ready` is high only in the cycle just before a bit boundary, and a bit is taken on the rising edge where both `in_valid` and `in_ready` are high. The source may hold `in_valid` high for as long as it likes. The source is back-pressured for the other cycle of every bit, and nothing it presents during that cycle is used. If `in_valid` is low at a boundary, the encoder sends an idle bit and flags an underrun for that bit. The mode select is a plain control input. It is read only at bit boundaries, so a change made in the middle of a bit takes effect at the next bit.

Top module: `line_code_encoder`

## Requirements
- R1: While `rst_n` is low and after it is released, `line_lvl` is 0 (`00`), `underrun` is 0 and `half_phase` is 1. `in_ready` is 0 while `rst_n` is low. The NRZI level register resets to -1, so the first NRZI `1` bit after reset drives +1.
- R2: `in_ready` equals `half_phase`. A bit transfers on a rising edge with `in_valid` and `in_ready` both high. The bit is on the line for the next two cycles, first half (`half_phase`=0) then second half (`half_phase`=1). Data and valid presented while `in_ready` is low are ignored.
- R3: In NRZ mode (`mode_sel`=`00`) the line is +1 for a `1` bit and -1 for a `0` bit, in both halves.
- R4: In NRZI mode (`mode_sel`=`01`) a `1` bit inverts the stored level between +1 and -1 and a `0` bit keeps it. The stored level is driven in both halves.
- R5: In RZ mode (`mode_sel`=`10`) the first half is +1 for a `1` bit and -1 for a `0` bit, and the second half is always 0.
- R6: In Manchester mode (`mode_sel`=`11`) each half is the data bit XOR a bit clock that is high in the first half. A `1` bit is sent as -1 then +1, and a `0` bit as +1 then -1. Every valid bit therefore has a mid-bit transition.
- R7: With no valid bit at a boundary, `underrun` is 1 for that whole bit. The line is 0 for both halves in RZ mode. In the other modes it holds the level it had just before the boundary.
- R8: The NRZI level register changes only on a valid NRZI bit. It keeps its value through underrun bits and through bits sent in other modes.
- R9: `mode_sel` is sampled only at bit boundaries. A change during the first half has no effect on the second half of the current bit.
- R10: `line_lvl` never takes the value `10`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Code select: 00 NRZ, 01 NRZI, 10 RZ, 11 Manchester |
| in_valid | input | 1 | Input bit is valid |
| in_ready | output | 1 | Encoder accepts a bit at this edge |
| in_data | input | 1 | Input data bit |
| line_lvl | output | 2 | Line level: 01 = +1, 00 = 0, 11 = -1 |
| half_phase | output | 1 | 0 during the first half of a bit, 1 during the second half |
| underrun | output | 1 | Current bit is an idle bit (no valid input at its boundary) |

## Verification
The assertions assume that `mode_sel`, `in_valid` and `in_data` carry known values at every rising edge. They also assume that reset is applied for at least one edge before the checks begin. Under those conditions the phase alternates, and the mode and underrun state stay fixed for a whole bit. The bench changes inputs only on falling edges and holds reset low for several cycles. Its one deliberate mid-bit change of the mode and data inputs falls in the first half, where the design must ignore it.

// File: rtl/lcenc_pkg.sv
package lcenc_pkg;
  typedef enum logic [1:0] {
    MODE_NRZ  = 2'b00,
    MODE_NRZI = 2'b01,
    MODE_RZ   = 2'b10,
    MODE_MAN  = 2'b11
  } line_mode_e;

  localparam int LVL_W = 2;
  localparam logic [LVL_W-1:0] LVL_POS  = 2'b01;
  localparam logic [LVL_W-1:0] LVL_ZERO = 2'b00;
  localparam logic [LVL_W-1:0] LVL_NEG  = 2'b11;

  function automatic logic [LVL_W-1:0] lvl_invert(input logic [LVL_W-1:0] l);
    return (l == LVL_POS) ? LVL_NEG : LVL_POS;
  endfunction
endpackage

// File: rtl/lcenc_half_timer.sv
module lcenc_half_timer (
  input  logic clk,
  input  logic rst_n,
  output logic half_q
);
  // half_q = 1: second half in progress, next edge is a bit boundary
  always_ff @(posedge clk) begin
    if (!rst_n) half_q <= 1'b1;
    else        half_q <= ~half_q;
  end
endmodule

// File: rtl/lcenc_bit_latch.sv
module lcenc_bit_latch
  import lcenc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  line_mode_e        mode_in,
  input  logic              bit_in,
  input  logic              vld_in,
  output line_mode_e        mode_q,
  output logic              bit_q,
  output logic              vld_q,
  output logic [LVL_W-1:0]  nrzi_q,
  output logic [LVL_W-1:0]  nrzi_next
);
  // NRZI reference moves only on an accepted NRZI one
  always_comb begin
    nrzi_next = nrzi_q;
    if (take && vld_in && mode_in == MODE_NRZI && bit_in)
      nrzi_next = lvl_invert(nrzi_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_NRZ;
      bit_q  <= 1'b0;
      vld_q  <= 1'b0;
      nrzi_q <= LVL_NEG;
    end else begin
      if (take) begin
        mode_q <= mode_in;
        bit_q  <= bit_in;
        vld_q  <= vld_in;
      end
      nrzi_q <= nrzi_next;
    end
  end

  assert_nrzi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && vld_in && mode_in == MODE_NRZI) |=> $stable(nrzi_q));
endmodule

// File: rtl/lcenc_level_gen.sv
module lcenc_level_gen
  import lcenc_pkg::*;
(
  input  logic              second,
  input  line_mode_e        mode,
  input  logic              data,
  input  logic              vld,
  input  logic [LVL_W-1:0]  nrzi_lvl,
  input  logic [LVL_W-1:0]  last_lvl,
  output logic [LVL_W-1:0]  lvl
);
  logic [LVL_W-1:0] polar;
  assign polar = data ? LVL_POS : LVL_NEG;

  always_comb begin
    if (!vld) begin
      lvl = (mode == MODE_RZ) ? LVL_ZERO : last_lvl;
    end else begin
      unique case (mode)
        MODE_NRZ:  lvl = polar;
        MODE_NRZI: lvl = nrzi_lvl;
        MODE_RZ:   lvl = second ? LVL_ZERO : polar;
        MODE_MAN:  lvl = (data == second) ? LVL_POS : LVL_NEG;
        default:   lvl = LVL_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/line_code_encoder.sv
module line_code_encoder
  import lcenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_data,
  output logic [1:0] line_lvl,
  output logic       half_phase,
  output logic       underrun
);
  logic             half_q;
  line_mode_e       mode_q, use_mode;
  logic             bit_q, vld_q, use_bit, use_vld;
  logic [LVL_W-1:0] nrzi_q, nrzi_next, use_nrzi, lvl_d, line_q;
  logic             under_q;

  lcenc_half_timer u_timer (.clk(clk), .rst_n(rst_n), .half_q(half_q));

  lcenc_bit_latch u_latch (
    .clk(clk), .rst_n(rst_n), .take(half_q),
    .mode_in(line_mode_e'(mode_sel)), .bit_in(in_data), .vld_in(in_valid),
    .mode_q(mode_q), .bit_q(bit_q), .vld_q(vld_q),
    .nrzi_q(nrzi_q), .nrzi_next(nrzi_next)
  );

  // At a boundary the fresh inputs set the first half; otherwise the latched bit sets the second half
  assign use_mode = half_q ? line_mode_e'(mode_sel) : mode_q;
  assign use_bit  = half_q ? in_data  : bit_q;
  assign use_vld  = half_q ? in_valid : vld_q;
  assign use_nrzi = half_q ? nrzi_next : nrzi_q;

  lcenc_level_gen u_gen (
    .second(~half_q), .mode(use_mode), .data(use_bit), .vld(use_vld),
    .nrzi_lvl(use_nrzi), .last_lvl(line_q), .lvl(lvl_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= LVL_ZERO;
      under_q <= 1'b0;
    end else begin
      line_q <= lvl_d;
      if (half_q) under_q <= ~in_valid;
    end
  end

  assign in_ready   = half_q & rst_n;
  assign line_lvl   = line_q;
  assign half_phase = half_q;
  assign underrun   = under_q;

  assert_level_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    line_lvl != 2'b10);
  assert_ready_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);
  assert_two_level_flat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_phase && (mode_q == MODE_NRZ || mode_q == MODE_NRZI)) |=> $stable(line_lvl));
  assert_rz_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_phase && mode_q == MODE_RZ) |=> line_lvl == LVL_ZERO);
  assert_man_midbit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_phase && mode_q == MODE_MAN && !underrun) |=> line_lvl != $past(line_lvl));
  assert_underrun_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !half_phase |=> $stable(underrun));
endmodule

// File: tb/tb_line_code_encoder.sv
module tb_line_code_encoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       in_valid = 1'b0;
  logic       in_data = 1'b0;
  logic       in_ready;
  logic [1:0] line_lvl;
  logic       half_phase;
  logic       underrun;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  line_code_encoder dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .line_lvl(line_lvl),
    .half_phase(half_phase), .underrun(underrun)
  );

  localparam logic [1:0] P = 2'b01, Z = 2'b00, N = 2'b11;

  // {mode, valid, data, first-half level, second-half level, underrun}
  localparam int NV = 19;
  localparam logic [8:0] VEC [NV] = '{
    {2'b00, 1'b1, 1'b1, P, P, 1'b0},  // R3
    {2'b00, 1'b1, 1'b0, N, N, 1'b0},  // R3
    {2'b01, 1'b1, 1'b1, P, P, 1'b0},  // R4 first one after reset
    {2'b01, 1'b1, 1'b0, P, P, 1'b0},  // R4
    {2'b01, 1'b1, 1'b1, N, N, 1'b0},  // R4
    {2'b10, 1'b1, 1'b1, P, Z, 1'b0},  // R5
    {2'b10, 1'b1, 1'b0, N, Z, 1'b0},  // R5
    {2'b11, 1'b1, 1'b1, N, P, 1'b0},  // R6
    {2'b11, 1'b1, 1'b0, P, N, 1'b0},  // R6
    {2'b11, 1'b0, 1'b1, N, N, 1'b1},  // R7 hold last
    {2'b01, 1'b1, 1'b1, P, P, 1'b0},  // R4
    {2'b01, 1'b0, 1'b0, P, P, 1'b1},  // R7
    {2'b10, 1'b1, 1'b0, N, Z, 1'b0},  // R5
    {2'b00, 1'b1, 1'b1, P, P, 1'b0},  // R3
    {2'b01, 1'b1, 1'b1, N, N, 1'b0},  // R8 state kept through other modes
    {2'b10, 1'b0, 1'b0, Z, Z, 1'b1},  // R7 RZ idle
    {2'b00, 1'b0, 1'b0, Z, Z, 1'b1},  // R7 hold last (zero)
    {2'b01, 1'b1, 1'b0, N, N, 1'b0},  // R8 state kept through gaps
    {2'b01, 1'b1, 1'b1, P, P, 1'b0}   // R4
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m, input logic v);
    if (!v) return "R7";
    case (m)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Starts and ends at a falling edge with half_phase = 1
  task automatic send(input logic [1:0] m, input logic v, input logic d,
                      input logic [1:0] e1, input logic [1:0] e2, input logic u);
    string t;
    t = mode_tag(m, v);
    mode_sel = m; in_valid = v; in_data = d;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk({t, " first half"}, int'(line_lvl), int'(e1));
    chk("R7 underrun flag", int'(underrun), int'(u));
    chk("R2 ready low in first half", int'(in_ready), 0);
    @(posedge clk); @(negedge clk);
    chk({t, " second half"}, int'(line_lvl), int'(e2));
    chk("R2 phase at boundary", int'(half_phase), 1);
  endtask

  initial begin
    for (int i = 0; i < 5000; i++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset level", int'(line_lvl), 0);
    chk("R1 reset underrun", int'(underrun), 0);
    chk("R1 reset phase", int'(half_phase), 1);
    chk("R1 ready low in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    #0.1;
    chk("R1 ready after release", int'(in_ready), 1);

    for (int i = 0; i < NV; i++)
      send(VEC[i][8:7], VEC[i][6], VEC[i][5], VEC[i][4:3], VEC[i][2:1], VEC[i][0]);

    // R9 and R2: mid-bit change of mode and data in the first half
    mode_sel = 2'b00; in_valid = 1'b1; in_data = 1'b1;
    @(posedge clk); @(negedge clk);
    mode_sel = 2'b10; in_valid = 1'b1; in_data = 1'b0;
    chk("R3 first half before mode change", int'(line_lvl), int'(P));
    @(posedge clk); @(negedge clk);
    chk("R9 mode change ignored mid-bit", int'(line_lvl), int'(P));
    in_valid = 1'b0;
    send(2'b10, 1'b1, 1'b1, P, Z, 1'b0);

    // R1: reset in the middle of a run clears NRZI reference (currently +1)
    send(2'b01, 1'b1, 1'b0, P, P, 1'b0);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 mid-run reset level", int'(line_lvl), 0);
    chk("R1 mid-run reset underrun", int'(underrun), 0);
    rst_n = 1'b1;
    send(2'b01, 1'b1, 1'b1, P, P, 1'b0);
    chk("R10 legal level", int'(line_lvl != 2'b10), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule